// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

This block is a direct-mapped data cache that sits next to a small, fully associative victim buffer. Each request is looked up in the indexed slot of the main array and in every victim entry in the same cycle. A hit in the main array is answered on the next cycle. A hit in the victim buffer costs one more cycle: the matching victim entry and the line in the indexed main slot trade places, so the requested line ends up in the main array. A miss in both structures fetches the block over a memory port that uses a valid/ready handshake. The valid line that the fill displaces from the main array then moves into the victim buffer.

Each line is one data word and carries a valid bit, a dirty bit and its address tag. Main-array lines hold the tag only. Victim entries hold the whole block address, because they are not tied to a set. Stores are write-back and write-allocate. When the victim buffer is full, its least recently inserted entry makes room for the incoming line. If that entry is dirty, it is written to memory before the fill read is issued. The response outcome is reported with each result, so a caller can tally main hits, victim hits and misses.

Top module: `vb_cache`

## Requirements
- R1: After reset, req_ready is 1, resp_valid is 0 and mem_req_valid is 0. The first access to any block is a miss.
- R2: A request that hits the main array gives resp_valid on the cycle after it is accepted, with resp_kind = 0. A load returns the most recently stored value of that address.
- R3: A request that misses the main array but hits a victim entry gives resp_valid two cycles after acceptance, with resp_kind = 1. The requested line and the line that was in the indexed main slot swap places, so the next access to the requested address is a main hit and the next access to the displaced address is a victim hit.
- R4: A request that misses both structures issues one memory read of its own address. It responds with resp_kind = 2 on the cycle after mem_rsp_valid. A load returns the fill data.
- R5: Every valid line that a fill displaces from the main array is placed in the victim buffer.
- R6: When a displaced main line enters a full victim buffer, the least recently inserted entry is dropped. Lines entering through a swap count as inserted. A dropped dirty entry causes one memory write of its block address and value before the fill read. A dropped clean entry causes no write.
- R7: Stores set the dirty bit of their line. Main hits and victim hits produce no memory traffic. Every load returns the most recently stored value.
- R8: Any address matches at most one victim entry, and never matches both the main array and a victim entry.
- R9: While mem_req_valid is high and mem_req_ready is low, mem_req_valid stays high and the request's address, direction and data stay unchanged.
- R10: req_ready is 0 from the cycle after a victim hit or a miss is accepted until its response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Cache idle and able to accept a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address of the access |
| req_wdata | input | DATA_W | Store data |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_kind | output | 2 | 0 main hit, 1 victim hit, 2 miss |
| resp_rdata | output | DATA_W | Load result (store data for stores) |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = write-back, 0 = fill read |
| mem_req_addr | output | ADDR_W | Block address of the memory request |
| mem_req_wdata | output | DATA_W | Write-back data |
| mem_rsp_valid | input | 1 | Fill data present |
| mem_rsp_data | input | DATA_W | Fill data |

## Verification
The hardest situation to reach is a dirty victim entry being dropped by a full buffer. This needs at least four displaced lines to have been stored to, the oldest of them dirty, and then one more conflicting miss. Swaps reorder the insertion history along the way. The bench gets there in two ways. One is a run of stores to many tags of a single index, which fills the buffer with dirty lines from one slot. The other is a long pseudo-random sweep over a few indexes and tags, with roughly half of the accesses being stores. A bench-side ordered list of victim entries predicts each outcome and each write-back, and a shadow memory checks every load value.

// File: rtl/vb_cache_pkg.sv
package vb_cache_pkg;
    parameter int ADDR_W  = 8;
    parameter int INDEX_W = 3;
    parameter int DATA_W  = 16;
    parameter int VICTIMS = 4;

    localparam int TAG_W  = ADDR_W - INDEX_W;
    localparam int SETS   = 1 << INDEX_W;
    localparam int VIDX_W = (VICTIMS > 1) ? $clog2(VICTIMS) : 1;

    typedef logic [ADDR_W-1:0]  addr_t;
    typedef logic [INDEX_W-1:0] index_t;
    typedef logic [TAG_W-1:0]   tag_t;
    typedef logic [DATA_W-1:0]  data_t;
    typedef logic [VIDX_W-1:0]  vslot_t;

    typedef enum logic [1:0] {
        OUT_MAIN_HIT   = 2'd0,
        OUT_VICTIM_HIT = 2'd1,
        OUT_MISS       = 2'd2
    } outcome_e;

    typedef enum logic [2:0] {
        S_IDLE, S_SWAP, S_WB, S_FILL, S_WAIT
    } state_e;

    typedef struct packed {
        logic  valid;
        logic  dirty;
        tag_t  tag;
        data_t data;
    } main_line_t;

    typedef struct packed {
        logic  valid;
        logic  dirty;
        addr_t blk;
        data_t data;
    } vict_line_t;

    function automatic index_t idx_of(addr_t a);
        return a[INDEX_W-1:0];
    endfunction

    function automatic tag_t tag_of(addr_t a);
        return a[ADDR_W-1:INDEX_W];
    endfunction
endpackage

// File: rtl/vb_main_array.sv
module vb_main_array
    import vb_cache_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  index_t     rd_idx,
    output main_line_t rd_line,
    input  logic       wr_en,
    input  index_t     wr_idx,
    input  main_line_t wr_line
);
    main_line_t lines [SETS];

    assign rd_line = lines[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < SETS; k++) lines[k] <= '0;
        end else if (wr_en) begin
            lines[wr_idx] <= wr_line;
        end
    end
endmodule

// File: rtl/vb_victim_buf.sv
module vb_victim_buf
    import vb_cache_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  addr_t              look_blk,
    output logic [VICTIMS-1:0] match,
    output vslot_t             hit_slot,
    output vict_line_t         hit_line,
    output vslot_t             rep_slot,
    output vict_line_t         rep_line,
    output logic               full,
    input  logic               ins_en,
    input  vslot_t             ins_slot,
    input  vict_line_t         ins_line
);
    vict_line_t          ent [VICTIMS];
    vslot_t              age [VICTIMS];
    logic [VICTIMS-1:0]  vld;
    logic [VIDX_W:0]     thr;

    for (genvar g = 0; g < VICTIMS; g++) begin : g_ent
        assign vld[g]   = ent[g].valid;
        assign match[g] = ent[g].valid && (ent[g].blk == look_blk);
    end

    always_comb begin
        hit_slot = '0;
        for (int k = 0; k < VICTIMS; k++)
            if (match[k]) hit_slot = vslot_t'(k);
    end

    // Lowest free slot first; otherwise the entry whose insertion rank is oldest.
    always_comb begin
        rep_slot = '0;
        for (int k = VICTIMS - 1; k >= 0; k--)
            if (vld[k] && age[k] == vslot_t'(VICTIMS - 1)) rep_slot = vslot_t'(k);
        for (int k = VICTIMS - 1; k >= 0; k--)
            if (!vld[k]) rep_slot = vslot_t'(k);
    end

    assign full     = &vld;
    assign hit_line = ent[hit_slot];
    assign rep_line = ent[rep_slot];
    assign thr      = vld[ins_slot] ? {1'b0, age[ins_slot]} : (VIDX_W + 1)'(VICTIMS);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < VICTIMS; k++) begin
                ent[k] <= '0;
                age[k] <= '0;
            end
        end else if (ins_en) begin
            for (int k = 0; k < VICTIMS; k++) begin
                if (vslot_t'(k) == ins_slot) begin
                    ent[k] <= ins_line;
                    age[k] <= '0;
                end else if (vld[k] && ({1'b0, age[k]} < thr)) begin
                    age[k] <= age[k] + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/vb_cache.sv
module vb_cache
    import vb_cache_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              resp_valid,
    output logic [1:0]        resp_kind,
    output logic [DATA_W-1:0] resp_rdata,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data
);
    state_e             state;
    outcome_e           kind_q;
    logic               cur_write;
    addr_t              cur_addr;
    data_t              cur_wdata;

    addr_t              look_addr;
    main_line_t         m_line;
    logic               main_hit;
    logic [VICTIMS-1:0] v_match;
    logic               v_hit;
    vslot_t             hit_slot;
    vslot_t             rep_slot;
    vict_line_t         hit_line;
    vict_line_t         rep_line;
    logic               v_full;
    logic               accept;
    logic               wb_needed;

    logic               m_we;
    main_line_t         m_wline;
    logic               v_ins;
    vslot_t             v_slot;
    vict_line_t         v_line;

    assign req_ready = (state == S_IDLE);
    assign accept    = req_valid && req_ready;
    assign look_addr = (state == S_IDLE) ? req_addr : cur_addr;
    assign main_hit  = m_line.valid && (m_line.tag == tag_of(look_addr));
    assign v_hit     = |v_match;
    assign wb_needed = m_line.valid && v_full && rep_line.dirty;
    assign resp_kind = kind_q;

    vb_main_array u_main (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (idx_of(look_addr)),
        .rd_line (m_line),
        .wr_en   (m_we),
        .wr_idx  (idx_of(look_addr)),
        .wr_line (m_wline)
    );

    vb_victim_buf u_victim (
        .clk      (clk),
        .rst      (rst),
        .look_blk (look_addr),
        .match    (v_match),
        .hit_slot (hit_slot),
        .hit_line (hit_line),
        .rep_slot (rep_slot),
        .rep_line (rep_line),
        .full     (v_full),
        .ins_en   (v_ins),
        .ins_slot (v_slot),
        .ins_line (v_line)
    );

    // Array and buffer write ports
    always_comb begin
        m_we    = 1'b0;
        m_wline = '0;
        v_ins   = 1'b0;
        v_slot  = rep_slot;
        v_line  = '{valid: m_line.valid, dirty: m_line.dirty,
                    blk: {m_line.tag, idx_of(look_addr)}, data: m_line.data};
        case (state)
            S_IDLE: if (accept && main_hit && req_write) begin
                m_we    = 1'b1;
                m_wline = '{valid: 1'b1, dirty: 1'b1, tag: tag_of(req_addr), data: req_wdata};
            end
            S_SWAP: begin
                m_we    = 1'b1;
                m_wline = '{valid: 1'b1, dirty: hit_line.dirty | cur_write,
                            tag: tag_of(cur_addr),
                            data: cur_write ? cur_wdata : hit_line.data};
                v_ins   = 1'b1;
                v_slot  = hit_slot;
            end
            S_WAIT: if (mem_rsp_valid) begin
                m_we    = 1'b1;
                m_wline = '{valid: 1'b1, dirty: cur_write, tag: tag_of(cur_addr),
                            data: cur_write ? cur_wdata : mem_rsp_data};
                v_ins   = m_line.valid;
            end
            default: ;
        endcase
    end

    assign mem_req_valid = (state == S_WB) || (state == S_FILL);
    assign mem_req_write = (state == S_WB);
    assign mem_req_addr  = (state == S_WB) ? rep_line.blk : cur_addr;
    assign mem_req_wdata = rep_line.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_IDLE;
            kind_q     <= OUT_MAIN_HIT;
            resp_valid <= 1'b0;
            resp_rdata <= '0;
            cur_write  <= 1'b0;
            cur_addr   <= '0;
            cur_wdata  <= '0;
        end else begin
            resp_valid <= 1'b0;
            case (state)
                S_IDLE: if (accept) begin
                    cur_write <= req_write;
                    cur_addr  <= req_addr;
                    cur_wdata <= req_wdata;
                    if (main_hit) begin
                        resp_valid <= 1'b1;
                        kind_q     <= OUT_MAIN_HIT;
                        resp_rdata <= req_write ? req_wdata : m_line.data;
                    end else if (v_hit) begin
                        state <= S_SWAP;
                    end else begin
                        state <= wb_needed ? S_WB : S_FILL;
                    end
                end
                S_SWAP: begin
                    state      <= S_IDLE;
                    resp_valid <= 1'b1;
                    kind_q     <= OUT_VICTIM_HIT;
                    resp_rdata <= cur_write ? cur_wdata : hit_line.data;
                end
                S_WB:   if (mem_req_ready) state <= S_FILL;
                S_FILL: if (mem_req_ready) state <= S_WAIT;
                S_WAIT: if (mem_rsp_valid) begin
                    state      <= S_IDLE;
                    resp_valid <= 1'b1;
                    kind_q     <= OUT_MISS;
                    resp_rdata <= cur_write ? cur_wdata : mem_rsp_data;
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/vb_cache_chk.sv
module vb_cache_chk
    import vb_cache_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_ready,
    input logic               resp_valid,
    input logic [1:0]         resp_kind,
    input logic               mem_req_valid,
    input logic               mem_req_ready,
    input logic               mem_req_write,
    input logic [ADDR_W-1:0]  mem_req_addr,
    input logic [DATA_W-1:0]  mem_req_wdata,
    input logic               main_hit,
    input logic [VICTIMS-1:0] v_match
);
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (req_ready && !resp_valid && !mem_req_valid));

    p_main_hit_resp_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && main_hit) |=> (resp_valid && resp_kind == 2'd0));

    p_victim_hit_resp_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !main_hit && (|v_match))
        |=> (!resp_valid && !req_ready) ##1 (resp_valid && resp_kind == 2'd1));

    p_miss_goes_out_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !main_hit && !(|v_match))
        |=> (!resp_valid && mem_req_valid && !req_ready));

    p_one_match_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(v_match));

    p_exclusive_place_r8: assert property (@(posedge clk) disable iff (rst)
        !(main_hit && (|v_match)));

    p_mem_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready)
        |=> (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)
             && (!mem_req_write || $stable(mem_req_wdata))));
endmodule

bind vb_cache vb_cache_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .resp_valid    (resp_valid),
    .resp_kind     (resp_kind),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .main_hit      (main_hit),
    .v_match       (v_match)
);

// File: tb/vb_cache_bench.sv
module vb_cache_bench;
    import vb_cache_pkg::*;

    localparam int MEM_WORDS = 1 << ADDR_W;

    logic  clk = 1'b0;
    logic  rst;
    logic  req_valid, req_ready, req_write;
    addr_t req_addr;
    data_t req_wdata;
    logic  resp_valid;
    logic [1:0] resp_kind;
    data_t resp_rdata;
    logic  mem_req_valid, mem_req_ready, mem_req_write;
    addr_t mem_req_addr;
    data_t mem_req_wdata;
    logic  mem_rsp_valid;
    data_t mem_rsp_data;

    always #2.5 clk = ~clk;

    vb_cache u_vb_cache (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_kind(resp_kind), .resp_rdata(resp_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // bench memory and its traffic log
    data_t mem [MEM_WORDS];
    int    wb_count = 0, rd_count = 0;
    addr_t wb_last_a, rd_last_a;
    data_t wb_last_d;
    int    stall = 0, seed = 0, rsp_wait = 0;
    bit    rsp_pending = 0;
    data_t rsp_data;

    // reference model: main tags, ordered victim list (oldest first), shadow values
    logic  mv [SETS];
    logic  md [SETS];
    tag_t  mt [SETS];
    addr_t qb [VICTIMS];
    logic  qd [VICTIMS];
    int    qn = 0;
    data_t shadow [MEM_WORDS];
    int    n_kind_dut [3];
    int    n_kind_mod [3];

    function automatic data_t init_val(int a);
        return data_t'(a * 37 + 5);
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // memory responder, acting on falling edges
    initial begin
        mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 0;
            if (mem_req_ready) begin
                mem_req_ready = 0;
            end else if (rsp_pending) begin
                if (rsp_wait == 0) begin
                    mem_rsp_valid = 1;
                    mem_rsp_data  = rsp_data;
                    rsp_pending   = 0;
                end else rsp_wait--;
            end else if (mem_req_valid) begin
                if (stall == 0) begin
                    mem_req_ready = 1;
                    seed++;
                    stall = seed % 3;
                    if (mem_req_write) begin
                        mem[mem_req_addr] = mem_req_wdata;
                        wb_count++;
                        wb_last_a = mem_req_addr;
                        wb_last_d = mem_req_wdata;
                    end else begin
                        rd_count++;
                        rd_last_a   = mem_req_addr;
                        rsp_data    = mem[mem_req_addr];
                        rsp_pending = 1;
                        rsp_wait    = seed % 2;
                    end
                end else stall--;
            end
        end
    end

    task automatic model_push(input addr_t b, input logic d);
        qb[qn] = b; qd[qn] = d; qn++;
    endtask

    task automatic model_remove(input int pos);
        for (int k = pos; k < qn - 1; k++) begin
            qb[k] = qb[k+1]; qd[k] = qd[k+1];
        end
        qn--;
    endtask

    task automatic model_step(input logic wr, input addr_t a, output int kind,
                              output bit wb, output addr_t wba);
        int   idx = int'(a) % SETS;
        tag_t tg  = tag_t'(int'(a) / SETS);
        int   pos = -1;
        logic vd;
        wb = 0; wba = '0;
        if (mv[idx] && mt[idx] == tg) begin
            kind = 0;
            if (wr) md[idx] = 1'b1;
        end else begin
            for (int k = 0; k < qn; k++) if (qb[k] == a) pos = k;
            if (pos >= 0) begin
                kind = 1;
                vd = qd[pos];
                model_remove(pos);
                model_push(addr_t'(int'(mt[idx]) * SETS + idx), md[idx]);
                mt[idx] = tg; md[idx] = vd | wr;
            end else begin
                kind = 2;
                if (mv[idx]) begin
                    if (qn == VICTIMS) begin
                        if (qd[0]) begin wb = 1; wba = qb[0]; end
                        model_remove(0);
                    end
                    model_push(addr_t'(int'(mt[idx]) * SETS + idx), md[idx]);
                end
                mv[idx] = 1'b1; mt[idx] = tg; md[idx] = wr;
            end
        end
    endtask

    task automatic do_access(input logic wr, input addr_t a, input data_t wd);
        int    kind, lat, wb0, rd0;
        bit    exp_wb;
        addr_t wba;
        data_t exp_d, wb_d;
        model_step(wr, a, kind, exp_wb, wba);
        wb_d  = shadow[wba];
        exp_d = wr ? wd : shadow[a];
        if (wr) shadow[a] = wd;
        n_kind_mod[kind]++;
        wb0 = wb_count; rd0 = rd_count;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 0;
        lat = 1;
        if (kind != 0) chk(req_ready == 0, "R10 busy after accept", req_ready, 0);
        while (!resp_valid && lat < 400) begin
            @(negedge clk);
            lat++;
        end
        chk(resp_valid == 1, "R4 response arrives", resp_valid, 1);
        if (resp_kind < 3) n_kind_dut[resp_kind]++;
        chk(resp_kind == 2'(kind), "R2/R3/R4 outcome kind", resp_kind, kind);
        chk(resp_rdata == exp_d, "R7 latest value", resp_rdata, exp_d);
        if (kind == 0) chk(lat == 1, "R2 main-hit latency", lat, 1);
        if (kind == 1) chk(lat == 2, "R3 victim-hit latency", lat, 2);
        chk((rd_count - rd0) == (kind == 2 ? 1 : 0), "R4 R7 read traffic", rd_count - rd0, kind == 2);
        if (kind == 2) chk(rd_last_a == a, "R4 fill address", rd_last_a, a);
        chk((wb_count - wb0) == int'(exp_wb), "R6 write-back count", wb_count - wb0, exp_wb);
        if (exp_wb) begin
            chk(wb_last_a == wba, "R6 write-back address", wb_last_a, wba);
            chk(wb_last_d == wb_d, "R6 write-back data", wb_last_d, wb_d);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog R4 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        for (int k = 0; k < MEM_WORDS; k++) begin
            mem[k] = init_val(k);
            shadow[k] = init_val(k);
        end
        for (int k = 0; k < SETS; k++) begin mv[k] = 0; md[k] = 0; mt[k] = '0; end
        for (int k = 0; k < 3; k++) begin n_kind_dut[k] = 0; n_kind_mod[k] = 0; end
        req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(req_ready == 1, "R1 ready after reset", req_ready, 1);
        chk(resp_valid == 0, "R1 no response after reset", resp_valid, 0);
        chk(mem_req_valid == 0, "R1 no memory request after reset", mem_req_valid, 0);

        // R1/R4: cold misses on every set, then main hits (R2)
        for (int i = 0; i < SETS; i++) do_access(0, addr_t'(i), '0);
        for (int i = 0; i < SETS; i++) do_access(0, addr_t'(i), '0);

        // R5: conflicting stores push clean lines into the victim buffer
        for (int i = 0; i < SETS; i++) do_access(1, addr_t'(i + SETS), data_t'(16'h1000 + i));

        // R3: ping-pong on one index swaps lines back and forth
        for (int r = 0; r < 6; r++) begin
            do_access(r[0], addr_t'(3), data_t'(16'h2000 + r));
            do_access(0, addr_t'(3 + SETS), '0);
        end

        // R6: dirty lines of one index overflow the victim buffer
        for (int t = 0; t < 12; t++) do_access(1, addr_t'(t * SETS), data_t'(16'h3000 + t));
        for (int t = 0; t < 12; t++) do_access(0, addr_t'(t * SETS), '0);

        // near-exhaustive mix over four indexes and eight tags
        lf = 16'hACE1;
        for (int n = 0; n < 2500; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            do_access(lf[0], addr_t'({3'(lf[7:5]), INDEX_W'(lf[2:1])}), data_t'(lf ^ 16'h5A5A));
        end

        for (int k = 0; k < 3; k++)
            chk(n_kind_dut[k] == n_kind_mod[k], "R2 R3 R4 outcome tally", n_kind_dut[k], n_kind_mod[k]);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule